// File: doc/BRIEF.md
# SDRAM Write Burst Interruption Controller

This block sits on the device side of a single-data-rate SDRAM. It follows the WRITE burst in progress across the banks. On every clock it decides whether the incoming data word goes into the array, and at which bank and column. Each command cycle carries a decoded command (idle, write, read or precharge), a bank, a column, a data word, a one-bit data mask and an auto-precharge flag. The block turns these into a registered array write strobe with bank, column and data, one precharge-done pulse per bank, a recovery-violation flag and an illegal-command flag.

A WRITE starts a burst whose column advances on each later cycle and wraps inside an aligned block the size of the burst length. In full-page mode the column wraps at the row end instead and the burst never ends by itself. A later WRITE, a READ, or a PRECHARGE to the bursting bank cuts the burst short.

Each bank keeps a count of clocks since its last unmasked word. A precharge that arrives before the write-recovery time has passed is flagged and held. It completes on the first edge where the recovery time is met. A precharge to a bank whose last WRITE asked for auto precharge is rejected as illegal.

Top module: `sdram_wr_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `arr_we`, `pre_done`, `twr_viol` and `illegal_cmd` are all low.
- R2: `cmd_in` uses the encoding 0 idle, 1 WRITE, 2 READ, 3 PRECHARGE. A WRITE with `dm_in` low causes, on the next cycle, `arr_we` high with `arr_bank`, `arr_col` and `arr_data` equal to that cycle's bank, column and data. WRITEs may target any bank on back-to-back cycles.
- R3: With burst length 4, the three cycles after a WRITE each write the current data word. The column advances by one, wrapping inside the aligned group of four (start 6 gives 6, 7, 4, 5). No word is written after the burst's last word.
- R4: A WRITE during a burst starts a new burst at its own bank and column. The interrupted burst gets no further words.
- R5: A READ writes nothing on its own cycle, and the interrupted burst writes nothing after it.
- R6: A cycle with `dm_in` high writes no word, but the burst column still advances.
- R7: A PRECHARGE to the bursting bank ends the burst, so no word is written on that cycle or after it. A PRECHARGE to another bank leaves the burst running and its words are still written.
- R8: A PRECHARGE to bank b that comes at least `TWR` edges (default 2) after bank b's last written word sets bit b of `pre_done` on the next cycle.
- R9: A PRECHARGE that comes earlier raises `twr_viol` on the next cycle and is held. Bit b of `pre_done` rises on the cycle after the edge that lies `TWR` edges past the last written word.
- R10: A PRECHARGE to a bank whose last WRITE had `ap_in` high raises `illegal_cmd` on the next cycle. It is ignored: no `pre_done`, no `twr_viol`, and the burst goes on.
- R11: In full-page mode the burst never ends by itself, and the column wraps from the last column of the row to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 2 | Decoded command: 0 idle, 1 WRITE, 2 READ, 3 PRECHARGE |
| bank_in | input | BANK_W | Bank of the command |
| col_in | input | COL_W | Start column of a WRITE |
| ap_in | input | 1 | Auto-precharge request carried with a WRITE |
| din | input | DATA_W | Write data word for this cycle |
| dm_in | input | 1 | Data mask; high suppresses this cycle's word |
| arr_we | output | 1 | Array write strobe |
| arr_bank | output | BANK_W | Bank being written |
| arr_col | output | COL_W | Column being written |
| arr_data | output | DATA_W | Word being written |
| pre_done | output | NUM_BANKS | One-cycle pulse per bank when a precharge takes effect |
| twr_viol | output | 1 | Precharge arrived before write recovery had elapsed |
| illegal_cmd | output | 1 | Explicit precharge after an auto-precharge write |

## Verification
Every array write, violation and illegal flag appears exactly one cycle after the edge that samples its command, because a single output register follows the decision logic. A held precharge instead completes one cycle after the edge lying `TWR` edges past its bank's last written word. The driver pushes the expected outputs for each command cycle at the falling edge where it applies the stimulus. The monitor pops and compares them just after the next rising edge, so each expectation is matched to the one register stage that produces it. Delayed precharge completions are written into the expectation of the exact later cycle, with zeros expected on the cycles between.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;
endpackage

// File: rtl/sdwr_burst.sv
module sdwr_burst
  import sdwr_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              dm,
  input  logic              pre_block,
  output logic              wr_now,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col
);
  localparam int LEFT_W = $clog2(BURST_LEN + 1);
  localparam logic [LEFT_W-1:0] FIRST_LEFT = LEFT_W'(BURST_LEN - 1);
  localparam logic [LEFT_W-1:0] ONE_LEFT   = LEFT_W'(1);
  localparam logic [COL_W-1:0]  ONE_COL    = COL_W'(1);
  localparam bit MULTI = FULL_PAGE || (BURST_LEN > 1);

  logic              act_q, act_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [COL_W-1:0]  nxt_q, nxt_n;
  logic [LEFT_W-1:0] left_q, left_n;
  logic [COL_W-1:0]  adv_in, adv_out;

  assign adv_in = (cmd == CMD_WRITE) ? col : nxt_q;

  // Column advance: row wrap for full page, aligned-group wrap otherwise
  generate
    if (FULL_PAGE) begin : g_row_wrap
      assign adv_out = adv_in + ONE_COL;
    end else if (BURST_LEN == 1) begin : g_single
      assign adv_out = adv_in;
    end else begin : g_group_wrap
      localparam int LBW = $clog2(BURST_LEN);
      localparam logic [LBW-1:0] ONE_LOW = LBW'(1);
      assign adv_out = {adv_in[COL_W-1:LBW], adv_in[LBW-1:0] + ONE_LOW};
    end
  endgenerate

  always_comb begin
    wr_now  = 1'b0;
    wr_bank = bank_q;
    wr_col  = nxt_q;
    act_n   = act_q;
    bank_n  = bank_q;
    nxt_n   = nxt_q;
    left_n  = left_q;
    unique case (cmd)
      CMD_WRITE: begin
        wr_now  = !dm;
        wr_bank = bank;
        wr_col  = col;
        bank_n  = bank;
        nxt_n   = adv_out;
        left_n  = FIRST_LEFT;
        act_n   = MULTI;
      end
      CMD_READ: begin
        act_n = 1'b0;
      end
      default: begin
        if (act_q && cmd == CMD_PRE && !pre_block && bank == bank_q) begin
          act_n = 1'b0;
        end else if (act_q) begin
          wr_now = !dm;
          nxt_n  = adv_out;
          if (!FULL_PAGE) begin
            left_n = left_q - ONE_LEFT;
            act_n  = (left_q != ONE_LEFT);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      nxt_q  <= '0;
      left_q <= '0;
    end else begin
      act_q  <= act_n;
      bank_q <= bank_n;
      nxt_q  <= nxt_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/sdwr_twr.sv
module sdwr_twr #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int TWR       = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_now,
  input  logic [BANK_W-1:0]    wr_bank,
  input  logic                 pre_req,
  input  logic [BANK_W-1:0]    pre_bank,
  output logic [NUM_BANKS-1:0] fire,
  output logic                 viol_any
);
  localparam int CNT_W = $clog2(TWR + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TWR);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_BANKS-1:0] viol_v;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cnt_q;
      logic             pend_q;
      logic             hit_w, hit_p, ready;

      assign hit_w     = wr_now && (wr_bank == BANK_W'(b));
      assign hit_p     = pre_req && (pre_bank == BANK_W'(b));
      assign ready     = (cnt_q >= CNT_MAX);
      assign fire[b]   = ready && (hit_p || pend_q);
      assign viol_v[b] = hit_p && !ready;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= CNT_MAX;
          pend_q <= 1'b0;
        end else begin
          if (hit_w)       cnt_q <= CNT_ONE;
          else if (!ready) cnt_q <= cnt_q + CNT_ONE;
          if (viol_v[b])    pend_q <= 1'b1;
          else if (fire[b]) pend_q <= 1'b0;
        end
      end
    end
  endgenerate

  assign viol_any = |viol_v;
endmodule

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
  import sdwr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  parameter int TWR       = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           cmd_in,
  input  logic [BANK_W-1:0]    bank_in,
  input  logic [COL_W-1:0]     col_in,
  input  logic                 ap_in,
  input  logic [DATA_W-1:0]    din,
  input  logic                 dm_in,
  output logic                 arr_we,
  output logic [BANK_W-1:0]    arr_bank,
  output logic [COL_W-1:0]     arr_col,
  output logic [DATA_W-1:0]    arr_data,
  output logic [NUM_BANKS-1:0] pre_done,
  output logic                 twr_viol,
  output logic                 illegal_cmd
);
  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] ap_q;
  logic                 illegal, pre_req;
  logic                 wr_now;
  logic [BANK_W-1:0]    wr_bank;
  logic [COL_W-1:0]     wr_col;
  logic [NUM_BANKS-1:0] fire;
  logic                 viol_any;

  assign cmd     = cmd_e'(cmd_in);
  assign illegal = (cmd == CMD_PRE) && ap_q[bank_in];
  assign pre_req = (cmd == CMD_PRE) && !illegal;

  always_ff @(posedge clk) begin
    if (rst) ap_q <= '0;
    else if (cmd == CMD_WRITE) ap_q[bank_in] <= ap_in;
  end

  sdwr_burst #(
    .COL_W(COL_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN), .FULL_PAGE(FULL_PAGE)
  ) u_burst (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank_in), .col(col_in), .dm(dm_in),
    .pre_block(illegal), .wr_now(wr_now), .wr_bank(wr_bank), .wr_col(wr_col)
  );

  sdwr_twr #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TWR(TWR)
  ) u_twr (
    .clk(clk), .rst(rst), .wr_now(wr_now), .wr_bank(wr_bank),
    .pre_req(pre_req), .pre_bank(bank_in), .fire(fire), .viol_any(viol_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we      <= 1'b0;
      arr_bank    <= '0;
      arr_col     <= '0;
      arr_data    <= '0;
      pre_done    <= '0;
      twr_viol    <= 1'b0;
      illegal_cmd <= 1'b0;
    end else begin
      arr_we      <= wr_now;
      arr_bank    <= wr_bank;
      arr_col     <= wr_col;
      arr_data    <= din;
      pre_done    <= fire;
      twr_viol    <= viol_any;
      illegal_cmd <= illegal;
    end
  end
endmodule

// File: rtl/sdwr_checker.sv
module sdwr_checker #(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int TWR       = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           cmd_in,
  input logic [BANK_W-1:0]    bank_in,
  input logic [COL_W-1:0]     col_in,
  input logic                 ap_in,
  input logic [DATA_W-1:0]    din,
  input logic                 dm_in,
  input logic                 arr_we,
  input logic [BANK_W-1:0]    arr_bank,
  input logic [COL_W-1:0]     arr_col,
  input logic [DATA_W-1:0]    arr_data,
  input logic [NUM_BANKS-1:0] pre_done,
  input logic                 twr_viol,
  input logic                 illegal_cmd
);
  AST_WRITE_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    (cmd_in == 2'd1 && !dm_in) |=> (arr_we && arr_bank == $past(bank_in)
      && arr_col == $past(col_in) && arr_data == $past(din))); // R2

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmd_in == 2'd2) |=> !arr_we); // R5

  AST_MASK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    dm_in |=> !arr_we); // R6

  AST_ILLEGAL_NO_VIOL: assert property (@(posedge clk) disable iff (rst)
    illegal_cmd |-> !twr_viol); // R10

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
      int gap_q;
      always_ff @(posedge clk) begin
        if (rst) gap_q <= TWR;
        else if (arr_we && arr_bank == BANK_W'(b)) gap_q <= 1;
        else if (gap_q < TWR) gap_q <= gap_q + 1;
      end
      AST_PRE_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        pre_done[b] |-> (gap_q >= TWR)); // R8
    end
  endgenerate
endmodule

bind sdram_wr_ctrl sdwr_checker #(
  .NUM_BANKS(NUM_BANKS), .COL_W(COL_W), .DATA_W(DATA_W), .TWR(TWR)
) u_chk (.*);

// File: tb/sim_sdram_wr_ctrl.sv
module sim_sdram_wr_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [1:0]  bank;
    logic [8:0]  col;
    logic [15:0] data;
    logic [3:0]  pd;
    logic        viol;
    logic        ill;
  } exp_t;

  typedef struct packed {
    logic        we;
    logic [8:0]  col;
    logic [15:0] data;
  } fexp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  cmd = 2'd0, bank = 2'd0;
  logic [8:0]  col = '0;
  logic        ap = 1'b0, dm = 1'b0;
  logic [15:0] din = '0;
  logic        we;
  logic [1:0]  obank;
  logic [8:0]  ocol;
  logic [15:0] odata;
  logic [3:0]  pd;
  logic        viol, ill;

  logic [1:0]  f_cmd = 2'd0;
  logic [8:0]  f_col = '0;
  logic [15:0] f_din = '0;
  logic        f_we;
  logic [1:0]  f_bank;
  logic [8:0]  f_ocol;
  logic [15:0] f_data;
  logic [3:0]  f_pd;
  logic        f_viol, f_ill;

  int checks = 0;
  int errors = 0;
  exp_t  q[$];
  string rq[$];
  fexp_t fq[$];
  string frq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_wr_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_in(cmd), .bank_in(bank), .col_in(col), .ap_in(ap),
    .din(din), .dm_in(dm), .arr_we(we), .arr_bank(obank), .arr_col(ocol),
    .arr_data(odata), .pre_done(pd), .twr_viol(viol), .illegal_cmd(ill)
  );

  sdram_wr_ctrl #(.FULL_PAGE(1'b1)) u1 (
    .clk(clk), .rst(rst), .cmd_in(f_cmd), .bank_in(2'd0), .col_in(f_col), .ap_in(1'b0),
    .din(f_din), .dm_in(1'b0), .arr_we(f_we), .arr_bank(f_bank), .arr_col(f_ocol),
    .arr_data(f_data), .pre_done(f_pd), .twr_viol(f_viol), .illegal_cmd(f_ill)
  );

  // Driver: apply one command cycle and queue the outputs due after the next edge
  task automatic step(input logic [1:0] c, input logic [1:0] b, input logic [8:0] cl,
                      input logic [15:0] d, input logic m, input logic a,
                      input logic ew, input logic [1:0] eb, input logic [8:0] ecol,
                      input logic [3:0] epd, input logic ev, input logic ei, input string r);
    exp_t e;
    @(negedge clk);
    cmd = c; bank = b; col = cl; din = d; dm = m; ap = a;
    e.we = ew; e.bank = eb; e.col = ecol; e.data = d; e.pd = epd; e.viol = ev; e.ill = ei;
    q.push_back(e);
    rq.push_back(r);
  endtask

  task automatic fstep(input logic [1:0] c, input logic [8:0] cl, input logic [15:0] d,
                       input logic ew, input logic [8:0] ecol, input string r);
    fexp_t e;
    @(negedge clk);
    f_cmd = c; f_col = cl; f_din = d;
    e.we = ew; e.col = ecol; e.data = d;
    fq.push_back(e);
    frq.push_back(r);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        string r;
        exp_t a;
        e = q.pop_front();
        r = rq.pop_front();
        a.we = we; a.bank = obank; a.col = ocol; a.data = odata;
        a.pd = pd; a.viol = viol; a.ill = ill;
        checks++;
        if (a.we !== e.we || a.pd !== e.pd || a.viol !== e.viol || a.ill !== e.ill ||
            (e.we && (a.bank !== e.bank || a.col !== e.col || a.data !== e.data))) begin
          errors++;
          $display("FAIL %s: actual we=%b bank=%0d col=%0d data=%h pd=%b viol=%b ill=%b expected we=%b bank=%0d col=%0d data=%h pd=%b viol=%b ill=%b",
                   r, a.we, a.bank, a.col, a.data, a.pd, a.viol, a.ill,
                   e.we, e.bank, e.col, e.data, e.pd, e.viol, e.ill);
        end
      end
      if (fq.size() > 0) begin
        fexp_t e;
        string r;
        e = fq.pop_front();
        r = frq.pop_front();
        checks++;
        if (f_we !== e.we || (e.we && (f_ocol !== e.col || f_data !== e.data))) begin
          errors++;
          $display("FAIL %s: actual we=%b col=%0d data=%h expected we=%b col=%0d data=%h",
                   r, f_we, f_ocol, f_data, e.we, e.col, e.data);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 during reset
    if (we !== 1'b0 || pd !== 4'b0 || viol !== 1'b0 || ill !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual we=%b pd=%b viol=%b ill=%b expected all 0", we, pd, viol, ill);
    end
    rst = 1'b0;
    step(2'd0, 2'd0, 9'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 9'd0, 4'b0000, 1'b0, 1'b0, "R1");

    // R2, R3: burst of four wrapping inside aligned group
    step(2'd1, 2'd1, 9'h006, 16'hA000, 1'b0, 1'b0, 1'b1, 2'd1, 9'h006, 4'b0, 1'b0, 1'b0, "R2");
    step(2'd0, 2'd0, 9'h000, 16'hA001, 1'b0, 1'b0, 1'b1, 2'd1, 9'h007, 4'b0, 1'b0, 1'b0, "R3");
    step(2'd0, 2'd0, 9'h000, 16'hA002, 1'b0, 1'b0, 1'b1, 2'd1, 9'h004, 4'b0, 1'b0, 1'b0, "R3");
    step(2'd0, 2'd0, 9'h000, 16'hA003, 1'b0, 1'b0, 1'b1, 2'd1, 9'h005, 4'b0, 1'b0, 1'b0, "R3");
    step(2'd0, 2'd0, 9'h000, 16'hA004, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R3");

    // R2, R4: back-to-back WRITEs, interrupted burst gets nothing more
    step(2'd1, 2'd0, 9'h010, 16'hB000, 1'b0, 1'b0, 1'b1, 2'd0, 9'h010, 4'b0, 1'b0, 1'b0, "R2");
    step(2'd1, 2'd2, 9'h020, 16'hB001, 1'b0, 1'b0, 1'b1, 2'd2, 9'h020, 4'b0, 1'b0, 1'b0, "R4");
    step(2'd0, 2'd0, 9'h000, 16'hB002, 1'b0, 1'b0, 1'b1, 2'd2, 9'h021, 4'b0, 1'b0, 1'b0, "R4");
    step(2'd0, 2'd0, 9'h000, 16'hB003, 1'b0, 1'b0, 1'b1, 2'd2, 9'h022, 4'b0, 1'b0, 1'b0, "R4");
    step(2'd0, 2'd0, 9'h000, 16'hB004, 1'b0, 1'b0, 1'b1, 2'd2, 9'h023, 4'b0, 1'b0, 1'b0, "R4");
    step(2'd0, 2'd0, 9'h000, 16'hB005, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R4");

    // R5: READ truncates
    step(2'd1, 2'd3, 9'h030, 16'hC000, 1'b0, 1'b0, 1'b1, 2'd3, 9'h030, 4'b0, 1'b0, 1'b0, "R5");
    step(2'd0, 2'd0, 9'h000, 16'hC001, 1'b0, 1'b0, 1'b1, 2'd3, 9'h031, 4'b0, 1'b0, 1'b0, "R5");
    step(2'd2, 2'd3, 9'h000, 16'hC002, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R5");
    step(2'd0, 2'd0, 9'h000, 16'hC003, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R5");

    // R6: mask skips word but column advances; then R8 on-time precharge
    step(2'd1, 2'd1, 9'h040, 16'hD000, 1'b1, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R6");
    step(2'd0, 2'd0, 9'h000, 16'hD001, 1'b0, 1'b0, 1'b1, 2'd1, 9'h041, 4'b0, 1'b0, 1'b0, "R6");
    step(2'd0, 2'd0, 9'h000, 16'hD002, 1'b1, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R6");
    step(2'd0, 2'd0, 9'h000, 16'hD003, 1'b0, 1'b0, 1'b1, 2'd1, 9'h043, 4'b0, 1'b0, 1'b0, "R6");
    step(2'd0, 2'd0, 9'h000, 16'hD004, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R6");
    step(2'd3, 2'd1, 9'h000, 16'hD005, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0010, 1'b0, 1'b0, "R8");
    step(2'd0, 2'd0, 9'h000, 16'hD006, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0000, 1'b0, 1'b0, "R8");

    // R9, R7: early same-bank precharge ends burst, held until recovery
    step(2'd1, 2'd2, 9'h050, 16'hE000, 1'b0, 1'b0, 1'b1, 2'd2, 9'h050, 4'b0, 1'b0, 1'b0, "R9");
    step(2'd3, 2'd2, 9'h000, 16'hE001, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0000, 1'b1, 1'b0, "R9");
    step(2'd0, 2'd0, 9'h000, 16'hE002, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0100, 1'b0, 1'b0, "R7");
    step(2'd0, 2'd0, 9'h000, 16'hE003, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0000, 1'b0, 1'b0, "R9");

    // R7: precharge to another bank leaves burst running
    step(2'd1, 2'd0, 9'h060, 16'hF000, 1'b0, 1'b0, 1'b1, 2'd0, 9'h060, 4'b0, 1'b0, 1'b0, "R7");
    step(2'd3, 2'd3, 9'h000, 16'hF001, 1'b0, 1'b0, 1'b1, 2'd0, 9'h061, 4'b1000, 1'b0, 1'b0, "R7");
    step(2'd0, 2'd0, 9'h000, 16'hF002, 1'b0, 1'b0, 1'b1, 2'd0, 9'h062, 4'b0, 1'b0, 1'b0, "R7");
    step(2'd0, 2'd0, 9'h000, 16'hF003, 1'b0, 1'b0, 1'b1, 2'd0, 9'h063, 4'b0, 1'b0, 1'b0, "R7");
    step(2'd0, 2'd0, 9'h000, 16'hF004, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R7");

    // R10: explicit precharge after auto-precharge write is rejected
    step(2'd1, 2'd3, 9'h070, 16'h1000, 1'b0, 1'b1, 1'b1, 2'd3, 9'h070, 4'b0, 1'b0, 1'b0, "R10");
    step(2'd3, 2'd3, 9'h000, 16'h1001, 1'b0, 1'b0, 1'b1, 2'd3, 9'h071, 4'b0, 1'b0, 1'b1, "R10");
    step(2'd0, 2'd0, 9'h000, 16'h1002, 1'b0, 1'b0, 1'b1, 2'd3, 9'h072, 4'b0, 1'b0, 1'b0, "R10");
    step(2'd0, 2'd0, 9'h000, 16'h1003, 1'b0, 1'b0, 1'b1, 2'd3, 9'h073, 4'b0, 1'b0, 1'b0, "R10");
    step(2'd0, 2'd0, 9'h000, 16'h1004, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 4'b0, 1'b0, 1'b0, "R10");

    // R11: full-page burst wraps at row end and runs until a READ
    fstep(2'd1, 9'd510, 16'h2000, 1'b1, 9'd510, "R11");
    fstep(2'd0, 9'd0,   16'h2001, 1'b1, 9'd511, "R11");
    fstep(2'd0, 9'd0,   16'h2002, 1'b1, 9'd0,   "R11");
    fstep(2'd0, 9'd0,   16'h2003, 1'b1, 9'd1,   "R11");
    fstep(2'd0, 9'd0,   16'h2004, 1'b1, 9'd2,   "R11");
    fstep(2'd0, 9'd0,   16'h2005, 1'b1, 9'd3,   "R11");
    fstep(2'd2, 9'd0,   16'h2006, 1'b0, 9'd0,   "R11");
    fstep(2'd0, 9'd0,   16'h2007, 1'b0, 9'd0,   "R11");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule